// File: doc/BRIEF.md
# Write-Through Set-Associative Data Cache

A four-way set-associative data cache that sits between a load/store port of a core and a single-transaction memory port. Every access moves one 128-bit line made of four 32-bit words. Loads that hit return the stored line one cycle after they are accepted. Stores that hit update the cached bytes selected by their byte enables and are always forwarded to memory. Because every store is forwarded, no line is ever dirty, and an eviction simply overwrites the chosen way.

Any miss allocates a line, whether it is a load or a store. The cache reads the whole line from memory and writes it into a way of the set. A load then returns the fetched line. A store merges its bytes into the fetched line and then forwards itself to memory. The replaced way is chosen from a three-bit pseudo-LRU tree kept for each set, and a way that holds no valid line is always used before any eviction. After reset, and on each pulse of the invalidate input, a counter walks the sets and clears one set per cycle. The core port is stalled during that walk.

The control is a four-state machine:
- `ST_CLEAR` walks the sets. It goes to `ST_IDLE` once the last set has been cleared.
- `ST_IDLE` serves hits. It goes to `ST_CLEAR` on invalidate, to `ST_FILL` on a miss, and to `ST_WRITE` on a store hit. A load hit stays in `ST_IDLE`.
- `ST_FILL` waits for the line read. On acknowledge it goes to `ST_IDLE` for a load, or to `ST_WRITE` for a store.
- `ST_WRITE` waits for the write-through. It goes to `ST_IDLE` on acknowledge.

The capacity is `SETS` × 4 ways × 16 bytes. The default of 128 sets gives 8 KB.

Top module: `wt_dcache`

## Requirements
- R1: After reset, and after a one-cycle `inv` pulse accepted in the idle state, `req_ready` stays low for exactly `SETS` cycles. Every line held before is then gone, so the next access to it misses.
- R2: A load hit asserts `rsp_valid` for one cycle, one cycle after acceptance, with the stored line on `rsp_rdata`. It issues no memory transaction and leaves `req_ready` high.
- R3: A load miss issues exactly one read on the memory port (`mem_we`=0, `mem_be` all ones, `mem_addr` equal to the request address with its low 4 bits cleared). It returns the line that memory delivered. At most one way of a set ever matches an address.
- R4: A store hit replaces byte i of the line (bits 8i+7..8i) only where bit i of `req_be` is set. It then issues one write (`mem_we`=1) carrying the line-aligned address, `req_wdata` and `req_be` unchanged. The cache asserts `rsp_valid` one cycle after `mem_ack`.
- R5: A store miss first reads the line from memory, then merges the store bytes into it, then issues the write-through. A later load of that line hits and returns the merged line.
- R6: `mem_req` stays high, with `mem_addr` and `mem_we` stable, from its rise until `mem_ack`. Only one transaction is outstanding at a time.
- R7: Each set keeps a tree t[2:0].
  - The victim is way 0 when t0=0 and t1=0, way 1 when t0=0 and t1=1, way 2 when t0=1 and t2=0, and way 3 when t0=1 and t2=1.
  - A hit or fill of way 0 or way 1 sets t0=1, and sets t1=1 for way 0 or t1=0 for way 1.
  - A hit or fill of way 2 or way 3 sets t0=0, and sets t2=1 for way 2 or t2=0 for way 3.
- R8: `req_ready` is low from the acceptance of any miss or store until its response cycle. It is also low whenever `mem_req` is high.
- R9: While a set has an invalid way, a miss in that set fills the lowest-numbered invalid way rather than the pseudo-LRU victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv | input | 1 | Pulse to invalidate every line |
| req_valid | input | 1 | Core request present |
| req_we | input | 1 | 1 for a store, 0 for a load |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | LINE_W | Store data, one full line |
| req_be | input | LINE_W/8 | Store byte enables |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | LINE_W | Line returned for a load |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | 1 for a write-through, 0 for a line read |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wdata | output | LINE_W | Write-through data |
| mem_be | output | LINE_W/8 | Write-through byte enables; all ones on reads |
| mem_ack | input | 1 | One-cycle completion from memory |
| mem_rdata | input | LINE_W | Line data, valid with mem_ack on a read |

## Verification
The assertions assume that memory raises `mem_ack` only while `mem_req` is high, and only for a single cycle per transaction. They also assume that `inv` is pulsed only while the cache is otherwise idle. The bench memory model acknowledges after a programmable delay of zero to three cycles and drops `mem_ack` on the following cycle. The bench drives `inv` only between completed accesses. Core requests are held until they are accepted and are released right after, so the stall checks are never confused by a request that is withdrawn.

// File: rtl/dc_pkg.sv
package dc_pkg;
    localparam int NWAYS  = 4;
    localparam int WAY_W  = 2;
    localparam int TREE_W = 3;

    typedef enum logic [1:0] {
        ST_CLEAR,
        ST_IDLE,
        ST_FILL,
        ST_WRITE
    } dc_state_e;
endpackage

// File: rtl/dc_plru.sv
module dc_plru import dc_pkg::*; (
    input  logic [TREE_W-1:0] tree,
    input  logic [WAY_W-1:0]  touch,
    output logic [WAY_W-1:0]  victim,
    output logic [TREE_W-1:0] tree_nxt
);
    // Root bit picks the half; the leaf bit of that half picks the way.
    always_comb begin
        if (tree[0]) victim = tree[2] ? 2'd3 : 2'd2;
        else         victim = tree[1] ? 2'd1 : 2'd0;
    end

    // Point every bit on the touched way's path away from it.
    always_comb begin
        tree_nxt = tree;
        if (!touch[1]) begin
            tree_nxt[0] = 1'b1;
            tree_nxt[1] = ~touch[0];
        end else begin
            tree_nxt[0] = 1'b0;
            tree_nxt[2] = ~touch[0];
        end
    end
endmodule

// File: rtl/dc_merge.sv
module dc_merge #(
    parameter int LINE_W = 128,
    localparam int BE_W  = LINE_W / 8
) (
    input  logic [LINE_W-1:0] old_line,
    input  logic [LINE_W-1:0] new_line,
    input  logic [BE_W-1:0]   be,
    output logic [LINE_W-1:0] merged
);
    for (genvar b = 0; b < BE_W; b++) begin : g_byte
        assign merged[8*b +: 8] = be[b] ? new_line[8*b +: 8] : old_line[8*b +: 8];
    end
endmodule

// File: rtl/wt_dcache.sv
module wt_dcache import dc_pkg::*; #(
    parameter int ADDR_W = 32,
    parameter int LINE_W = 128,
    parameter int SETS   = 128,
    localparam int BE_W  = LINE_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inv,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LINE_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [LINE_W-1:0] rsp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    output logic [BE_W-1:0]   mem_be,
    input  logic              mem_ack,
    input  logic [LINE_W-1:0] mem_rdata
);
    localparam int OFF_W = $clog2(BE_W);
    localparam int IDX_W = $clog2(SETS);
    localparam int LA_W  = ADDR_W - OFF_W;
    localparam int TAG_W = LA_W - IDX_W;

    // Storage
    logic [LINE_W-1:0] data_q  [SETS][NWAYS];
    logic [TAG_W-1:0]  tag_q   [SETS][NWAYS];
    logic [NWAYS-1:0]  valid_q [SETS];
    logic [TREE_W-1:0] plru_q  [SETS];

    // Control and request latch
    dc_state_e         st, st_nxt;
    logic [IDX_W-1:0]  clr_cnt;
    logic [LA_W-1:0]   lat_line;
    logic              lat_we;
    logic [LINE_W-1:0] lat_wdata;
    logic [BE_W-1:0]   lat_be;
    logic [WAY_W-1:0]  lat_way;

    // Lookup
    logic [IDX_W-1:0]  req_idx, lat_idx, cur_idx;
    logic [TAG_W-1:0]  req_tag, lat_tag;
    logic [NWAYS-1:0]  hit_vec;
    logic              hit, all_valid, accept;
    logic [WAY_W-1:0]  hit_way, free_way, plru_victim, victim, touch;
    logic [TREE_W-1:0] plru_nxt;
    logic [LINE_W-1:0] hit_data, m_old, m_new, merged;
    logic [BE_W-1:0]   m_be;

    assign req_idx = req_addr[OFF_W +: IDX_W];
    assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
    assign lat_idx = lat_line[IDX_W-1:0];
    assign lat_tag = lat_line[LA_W-1 -: TAG_W];

    for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
        assign hit_vec[w] = valid_q[req_idx][w] && (tag_q[req_idx][w] == req_tag);
    end

    always_comb begin
        hit_way  = '0;
        free_way = '0;
        for (int w = 0; w < NWAYS; w++)
            if (hit_vec[w]) hit_way = WAY_W'(w);
        for (int w = NWAYS - 1; w >= 0; w--)
            if (!valid_q[req_idx][w]) free_way = WAY_W'(w);
    end

    assign hit       = |hit_vec;
    assign all_valid = &valid_q[req_idx];
    assign hit_data  = data_q[req_idx][hit_way];
    assign cur_idx   = (st == ST_IDLE) ? req_idx : lat_idx;
    assign touch     = (st == ST_IDLE) ? hit_way : lat_way;
    assign victim    = all_valid ? plru_victim : free_way;
    assign req_ready = (st == ST_IDLE) && !inv;
    assign accept    = req_valid && req_ready;

    assign m_old = (st == ST_IDLE) ? hit_data  : mem_rdata;
    assign m_new = (st == ST_IDLE) ? req_wdata : lat_wdata;
    assign m_be  = (st == ST_IDLE) ? req_be    : lat_be;

    dc_plru u_plru (
        .tree     (plru_q[cur_idx]),
        .touch    (touch),
        .victim   (plru_victim),
        .tree_nxt (plru_nxt)
    );

    dc_merge #(.LINE_W(LINE_W)) u_merge (
        .old_line (m_old),
        .new_line (m_new),
        .be       (m_be),
        .merged   (merged)
    );

    // Next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_CLEAR: if (clr_cnt == IDX_W'(SETS - 1)) st_nxt = ST_IDLE;
            ST_IDLE: begin
                if (inv)         st_nxt = ST_CLEAR;
                else if (accept) st_nxt = !hit ? ST_FILL : (req_we ? ST_WRITE : ST_IDLE);
            end
            ST_FILL:  if (mem_ack) st_nxt = lat_we ? ST_WRITE : ST_IDLE;
            ST_WRITE: if (mem_ack) st_nxt = ST_IDLE;
        endcase
    end

    // State register and reset-bearing control
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_CLEAR;
            clr_cnt   <= '0;
            rsp_valid <= 1'b0;
        end else begin
            st        <= st_nxt;
            rsp_valid <= (accept && hit && !req_we) ||
                         (st == ST_FILL && mem_ack && !lat_we) ||
                         (st == ST_WRITE && mem_ack);
            if (st == ST_CLEAR)
                clr_cnt <= (clr_cnt == IDX_W'(SETS - 1)) ? '0 : clr_cnt + 1'b1;
        end
    end

    // Arrays, request latch and response data
    always_ff @(posedge clk) begin
        unique case (st)
            ST_CLEAR: begin
                valid_q[clr_cnt] <= '0;
                plru_q[clr_cnt]  <= '0;
            end
            ST_IDLE: if (accept) begin
                lat_line  <= req_addr[ADDR_W-1:OFF_W];
                lat_we    <= req_we;
                lat_wdata <= req_wdata;
                lat_be    <= req_be;
                lat_way   <= victim;
                if (hit) begin
                    plru_q[req_idx] <= plru_nxt;
                    if (req_we) data_q[req_idx][hit_way] <= merged;
                    else        rsp_rdata <= hit_data;
                end
            end
            ST_FILL: if (mem_ack) begin
                data_q[lat_idx][lat_way]  <= lat_we ? merged : mem_rdata;
                tag_q[lat_idx][lat_way]   <= lat_tag;
                valid_q[lat_idx][lat_way] <= 1'b1;
                plru_q[lat_idx]           <= plru_nxt;
                if (!lat_we) rsp_rdata <= mem_rdata;
            end
            ST_WRITE: ;
        endcase
    end

    // Memory port
    always_comb begin
        mem_req   = (st == ST_FILL) || (st == ST_WRITE);
        mem_we    = (st == ST_WRITE);
        mem_addr  = {lat_line, {OFF_W{1'b0}}};
        mem_wdata = lat_wdata;
        mem_be    = (st == ST_WRITE) ? lat_be : '1;
    end
endmodule

// File: rtl/dc_chk.sv
module dc_chk import dc_pkg::*; #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              inv,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic [NWAYS-1:0]  hit_vec,
    input logic              lat_we,
    input dc_state_e         st
);
    // R6
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

    // R8
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    // R1
    inv_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv && st == ST_IDLE |=> !req_ready);

    // R5
    alloc_wt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ack && lat_we |=> mem_req && mem_we);

    // R3
    one_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |-> $onehot0(hit_vec));
endmodule

bind wt_dcache dc_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .inv       (inv),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .hit_vec   (hit_vec),
    .lat_we    (lat_we),
    .st        (st)
);

// File: tb/wt_dcache_bench.sv
`timescale 1ns/1ps
module wt_dcache_bench;
    localparam int SETS = 8;
    localparam int AW   = 32;
    localparam int LW   = 128;
    localparam int BW   = 16;

    logic          clk = 0, rst_n = 0, inv = 0;
    logic          req_valid = 0, req_we = 0;
    logic [AW-1:0] req_addr = '0;
    logic [LW-1:0] req_wdata = '0;
    logic [BW-1:0] req_be = '0;
    logic          req_ready, rsp_valid, mem_req, mem_we;
    logic [LW-1:0] rsp_rdata, mem_wdata;
    logic [AW-1:0] mem_addr;
    logic [BW-1:0] mem_be;
    logic          mem_ack = 0;
    logic [LW-1:0] mem_rdata = '0;

    int checks = 0, fails = 0, cyc = 0;

    wt_dcache #(.ADDR_W(AW), .LINE_W(LW), .SETS(SETS)) u_wt_dcache (
        .clk(clk), .rst_n(rst_n), .inv(inv),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    // ---------------- memory model ----------------
    logic [LW-1:0] mdl [logic [AW-1:0]];
    int            mem_lat = 1, pend = 0, rd_cnt = 0, wr_cnt = 0, hold_err = 0;
    int            rd_stamp = 0, wr_stamp = 0;
    logic [AW-1:0] held = '0, last_rd = '0, last_wr = '0;
    logic [LW-1:0] last_wd = '0;
    logic [BW-1:0] last_be = '0, last_rbe = '0;

    function automatic logic [LW-1:0] pat(input logic [AW-1:0] a);
        return {a ^ 32'h4444_0004, a ^ 32'h3333_0003, a ^ 32'h2222_0002, a ^ 32'h1111_0001};
    endfunction

    function automatic logic [LW-1:0] bmerge(input logic [LW-1:0] o, input logic [LW-1:0] n,
                                             input logic [BW-1:0] be);
        logic [LW-1:0] r = o;
        for (int b = 0; b < BW; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    function automatic logic [LW-1:0] mem_get(input logic [AW-1:0] a);
        return mdl.exists(a) ? mdl[a] : pat(a);
    endfunction

    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 0;
        end else if (mem_req) begin
            if (pend == 0) held = mem_addr;
            else if (mem_addr != held) hold_err++;
            if (pend >= mem_lat) begin
                if (mem_we) begin
                    mdl[mem_addr] = bmerge(mem_get(mem_addr), mem_wdata, mem_be);
                    wr_cnt++; wr_stamp = cyc; last_wr = mem_addr;
                    last_wd = mem_wdata; last_be = mem_be;
                end else begin
                    mem_rdata = mem_get(mem_addr);
                    rd_cnt++; rd_stamp = cyc; last_rd = mem_addr; last_rbe = mem_be;
                end
                mem_ack = 1; pend = 0;
            end else pend++;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input string what,
                         input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [AW-1:0] a, input logic [LW-1:0] wd,
                          input logic [BW-1:0] be, output logic [LW-1:0] rd,
                          output int lat, output bit rdy1);
        @(negedge clk);
        req_valid = 1; req_we = we; req_addr = a; req_wdata = wd; req_be = be;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        lat = 1; rdy1 = req_ready;
        while (!rsp_valid) begin @(negedge clk); lat++; end
        rd = rsp_rdata;
    endtask

    task automatic count_stall(output int n);
        n = 0;
        while (!req_ready) begin @(negedge clk); n++; end
    endtask

    // ---------------- scenarios ----------------
    localparam logic [AW-1:0] XA = 32'h0000_0914;  // set 1
    localparam logic [AW-1:0] XL = 32'h0000_0910;
    localparam logic [AW-1:0] YA = 32'h0000_0A28;  // set 2
    localparam logic [AW-1:0] YL = 32'h0000_0A20;

    task automatic t_reset();
        int n;
        rst_n = 0;
        repeat (3) @(negedge clk);
        check(!req_ready && !rsp_valid && !mem_req, "R1", "reset outputs",
              {req_ready, rsp_valid, mem_req}, 0);
        rst_n = 1;
        count_stall(n);
        check(n == SETS, "R1", "clear cycles after reset", n, SETS);
    endtask

    task automatic t_read_miss();
        logic [LW-1:0] d; int l; bit r; int r0 = rd_cnt, w0 = wr_cnt;
        mem_lat = 2;
        access(0, XA, '0, '0, d, l, r);
        check(rd_cnt == r0 + 1 && wr_cnt == w0, "R3", "one fill read", rd_cnt - r0, 1);
        check(last_rd == XL, "R3", "fill address aligned", last_rd, XL);
        check(last_rbe == '1, "R3", "fill byte enables", last_rbe, 16'hFFFF);
        check(d == pat(XL), "R3", "miss data", d, pat(XL));
        check(r == 0, "R8", "stall during fill", r, 0);
    endtask

    task automatic t_read_hit();
        logic [LW-1:0] d; int l; bit r; int r0 = rd_cnt;
        access(0, XA, '0, '0, d, l, r);
        check(rd_cnt == r0, "R2", "hit makes no read", rd_cnt - r0, 0);
        check(l == 1, "R2", "hit latency", l, 1);
        check(r == 1, "R2", "ready stays high", r, 1);
        check(d == pat(XL), "R2", "hit data", d, pat(XL));
    endtask

    task automatic t_store_hit();
        logic [LW-1:0] d, wd, exp; int l; bit r; int r0 = rd_cnt, w0 = wr_cnt;
        mem_lat = 3;
        wd = {4{32'hDEAD_BEEF}};
        exp = bmerge(pat(XL), wd, 16'h00F0);
        access(1, XA, wd, 16'h00F0, d, l, r);
        check(wr_cnt == w0 + 1 && rd_cnt == r0, "R4", "one write-through", wr_cnt - w0, 1);
        check(last_wr == XL && last_be == 16'h00F0, "R4", "write addr/be",
              {last_wr, last_be}, {XL, 16'h00F0});
        check(last_wd == wd, "R4", "write data", last_wd, wd);
        check(r == 0 && l == mem_lat + 2, "R8", "store stalls until ack", l, mem_lat + 2);
        access(0, XA, '0, '0, d, l, r);
        check(d == exp && rd_cnt == r0, "R4", "merged line held", d, exp);
    endtask

    task automatic t_store_miss();
        logic [LW-1:0] d, wd, exp; int l; bit r; int r0 = rd_cnt, w0 = wr_cnt;
        mem_lat = 0;
        wd = {4{32'h0BAD_F00D}};
        exp = bmerge(pat(YL), wd, 16'hF00F);
        access(1, YA, wd, 16'hF00F, d, l, r);
        check(rd_cnt == r0 + 1 && wr_cnt == w0 + 1, "R5", "fill plus write",
              {rd_cnt - r0, wr_cnt - w0}, {32'd1, 32'd1});
        check(rd_stamp < wr_stamp, "R5", "fill before write", rd_stamp, wr_stamp);
        check(last_wd == wd && last_be == 16'hF00F, "R5", "write-through content", last_wd, wd);
        access(0, YA, '0, '0, d, l, r);
        check(d == exp && rd_cnt == r0 + 1, "R5", "allocated merged line", d, exp);
    endtask

    task automatic t_plru();
        logic [LW-1:0] d; int l; bit r; int r0;
        logic [AW-1:0] a [5] = '{32'h1050, 32'h2050, 32'h3050, 32'h4050, 32'h5050};
        mem_lat = 1;
        for (int i = 0; i < 4; i++) access(0, a[i], '0, '0, d, l, r);
        r0 = rd_cnt;
        for (int i = 0; i < 4; i++) access(0, a[i], '0, '0, d, l, r);
        check(rd_cnt == r0, "R9", "four lines fill four ways", rd_cnt - r0, 0);
        // tree now 000; touching way 0 gives t0=1,t1=1 -> victim way 2 (third line)
        access(0, a[0], '0, '0, d, l, r);
        access(0, a[4], '0, '0, d, l, r);
        check(rd_cnt == r0 + 1 && d == pat(a[4]), "R7", "new line filled",
              rd_cnt - r0, 1);
        access(0, a[0], '0, '0, d, l, r);
        access(0, a[1], '0, '0, d, l, r);
        access(0, a[3], '0, '0, d, l, r);
        check(rd_cnt == r0 + 1, "R7", "ways 0,1,3 kept", rd_cnt - r0, 1);
        access(0, a[2], '0, '0, d, l, r);
        check(rd_cnt == r0 + 2, "R7", "way 2 was evicted", rd_cnt - r0, 2);
    endtask

    task automatic t_invalidate();
        logic [LW-1:0] d; int l; bit r; int n; int r0;
        @(negedge clk); inv = 1;
        @(negedge clk); inv = 0;
        count_stall(n);
        check(n == SETS, "R1", "clear cycles after inv", n, SETS);
        r0 = rd_cnt;
        access(0, XA, '0, '0, d, l, r);
        check(rd_cnt == r0 + 1, "R1", "line gone after inv", rd_cnt - r0, 1);
        check(d == mem_get(XL), "R1", "refetched data", d, mem_get(XL));
    endtask

    task automatic t_hold();
        check(hold_err == 0, "R6", "request stable until ack", hold_err, 0);
    endtask

    initial begin
        t_reset();
        t_read_miss();
        t_read_hit();
        t_store_hit();
        t_store_miss();
        t_plru();
        t_invalidate();
        t_hold();
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule